// File: doc/BRIEF.md
# Dual Serial Port with Coded Rate Select

This block holds two identical asynchronous serial channels behind one 16-bit register bus. Each channel has three registers. The data register accepts a byte into a four-entry transmit queue on write and hands back the oldest received byte on read. The rate register holds a four-bit code that picks the line speed. A write of any value to the clear register returns that channel to its power-up state. Frames are 8N1: one low start bit, eight data bits sent least significant bit first, then one high stop bit. The line idles high.

Software selects a speed, writes bytes into the data register and reads bytes back from the same address. The two status outputs per channel show whether the receive queue is empty and whether any byte was lost. A byte is lost either because it was written to a full transmit queue or because it arrived while the receive queue was full. The oversampling tick is derived from the system clock. Its period doubles for each step down in the rate code, so the slowest code gives bits 256 times longer than the fastest. The receiver samples each bit at 16 times the bit rate, near the middle of the bit.

The bus address is `{channel, register}`. Channel A is channel 0 and channel B is channel 1. Register 0 is data, register 1 is rate, register 2 is clear, and register 3 reads as zero. Read data appears on `bus_rdata` in the cycle after the read strobe.

Top module: `duo_uart`

## Requirements
- R1: After system reset, both serial outputs are high, both receive queues report empty, all loss flags are 0, and each rate register reads 0, which is the slowest speed.
- R2: A byte written to a channel's data register leaves that channel's serial output as a frame: a low start bit, data bit 0 first through bit 7, then a high stop bit. The receiving channel then returns the same byte in bits 7:0 of a data-register read.
- R3: The transmit queue holds 4 bytes. A data write while the queue is full is dropped and sets the channel's `tx_ovf` bit, which stays set until the channel is cleared.
- R4: A data-register read while the receive queue is empty returns 0x0000 and leaves `rx_empty` high.
- R5: Rate code n (write data bits 11:8, n = 0 to 8) gives a bit time of 16 × FAST_DIV × 2^(8−n) clock cycles. Bits 15:12 of the written word have no effect.
- R6: A rate-register read returns the stored code in bits 11:8 and zeros in all other bits.
- R7: Any write to a channel's clear register, whatever the data, does all of the following in the next cycle: sets the rate code to 0, empties both queues, aborts a frame in progress (the serial output goes high), and clears both loss flags.
- R8: A received frame that finds the 4-entry receive queue full is dropped and sets `rx_ovf`. This flag stays set until the channel is cleared. The four bytes already queued are read back in arrival order.
- R9: A received frame whose stop bit is low is discarded and queues nothing.
- R10: Rate writes, clear writes and queue traffic on one channel leave the other channel's rate code and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| bus_addr | input | 3 | {channel, register}: register 0 data, 1 rate, 2 clear |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| ser_rx | input | 2 | Serial inputs, index = channel |
| ser_tx | output | 2 | Serial outputs, index = channel, idle high |
| rx_empty | output | 2 | Receive queue empty, per channel |
| tx_ovf | output | 2 | Sticky: a write hit a full transmit queue |
| rx_ovf | output | 2 | Sticky: a received byte found the receive queue full |

## Verification
Some properties are checked on every cycle. The loss flags must stay set until a clear write. A clear write must leave the line high, the receive queue empty and both flags low one cycle later. An empty-queue data read must return zero, and a rate read must return zeros outside the code field. The bench scenarios cover what needs a whole frame or a timed measurement. They measure the start-bit length at the slowest, middle and fastest codes. They decode the transmitted bits, check receive-queue order across an overflow, and confirm that a frame with a low stop bit is dropped. They also check that one channel's clear and rate writes leave the other channel alone.

// File: rtl/duo_uart_pkg.sv
// Shared constants and register-offset encoding for the dual serial port.
// Assumes the bus address is {channel, offset[1:0]}.
package duo_uart_pkg;
    typedef enum logic [1:0] {
        OFF_DATA  = 2'd0,
        OFF_RATE  = 2'd1,
        OFF_CLEAR = 2'd2,
        OFF_NONE  = 2'd3
    } reg_off_e;

    localparam int RATE_W   = 4;   // width of the rate code field
    localparam int MAX_CODE = 8;   // fastest defined code
    localparam int OSR      = 16;  // oversampling ticks per bit
    localparam int BYTE_W   = 8;
    localparam int BUS_W    = 16;
endpackage

// File: rtl/duo_uart_baud.sv
// Oversampling tick generator. Emits one tick every FAST_DIV << (8 - code)
// clocks. Codes above the fastest defined code behave as the fastest code.
// Assumes clr and rate changes may happen at any time; the counter restarts on clr.
module duo_uart_baud
    import duo_uart_pkg::*;
#(
    parameter int FAST_DIV = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [RATE_W-1:0] code,
    output logic              tick
);
    localparam int MAX_DIV = FAST_DIV << MAX_CODE;
    localparam int CW      = $clog2(MAX_DIV + 1);

    logic [CW-1:0]     cnt;
    logic [CW-1:0]     lim;
    logic [RATE_W-1:0] code_eff;

    // Clamp the code and derive the tick period.
    always_comb begin
        code_eff = (code > RATE_W'(MAX_CODE)) ? RATE_W'(MAX_CODE) : code;
        lim      = CW'(FAST_DIV) << (RATE_W'(MAX_CODE) - code_eff);
    end

    assign tick = (cnt >= lim - CW'(1));

    // Free-running period counter, restarted by reset or channel clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) cnt <= '0;
        else                       cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/duo_uart_fifo.sv
// Small synchronous queue. A push when full or a pop when empty is ignored.
// dout shows the oldest entry combinationally.
module duo_uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;

    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign dout  = mem[rp[AW-1:0]];

    // Pointer update; clear empties the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full) wp <= wp + 1'b1;
            if (pop && !empty) rp <= rp + 1'b1;
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push && !full) mem[wp[AW-1:0]] <= din;
    end
endmodule

// File: rtl/duo_uart_tx.sv
// 8N1 transmitter. Starts a frame only on an oversampling tick, so every bit
// lasts exactly 16 ticks. clr aborts a frame and returns the line high.
module duo_uart_tx
    import duo_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic              q_empty,
    input  logic [BYTE_W-1:0] q_data,
    output logic              q_pop,
    output logic              txd
);
    logic                busy;
    logic [BYTE_W+1:0]   shr;
    logic [3:0]          sub;
    logic [3:0]          bitn;

    assign q_pop = !busy && tick && !q_empty && !clr;
    assign txd   = busy ? shr[0] : 1'b1;

    // Frame sequencing: load, then shift one bit every 16 ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy <= 1'b0;
            shr  <= '1;
            sub  <= '0;
            bitn <= '0;
        end else if (q_pop) begin
            busy <= 1'b1;
            shr  <= {1'b1, q_data, 1'b0};
            sub  <= '0;
            bitn <= '0;
        end else if (busy && tick) begin
            sub <= sub + 4'd1;
            if (sub == 4'(OSR - 1)) begin
                shr  <= {1'b1, shr[BYTE_W+1:1]};
                bitn <= bitn + 4'd1;
                if (bitn == 4'd9) busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/duo_uart_rx.sv
// 8N1 receiver with 16x oversampling. It confirms the start bit at mid-bit,
// samples each data bit near its centre, and reports a byte only when the
// stop bit is high. After a low stop bit, it waits for the line to go high
// before it looks for a new start.
module duo_uart_rx
    import duo_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic              rxd,
    output logic              valid,
    output logic [BYTE_W-1:0] data
);
    logic       s1, s2;
    logic       busy, last;
    logic [3:0] sub;
    logic [3:0] bitn;

    // Two-stage synchronizer for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= rxd;
            s2 <= s1;
        end
    end

    // Start detection, bit sampling and stop-bit validation.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy  <= 1'b0;
            last  <= 1'b1;
            sub   <= '0;
            bitn  <= '0;
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= 1'b0;
            if (tick) begin
                if (!busy) begin
                    last <= s2;
                    if (last && !s2) begin
                        busy <= 1'b1;
                        sub  <= '0;
                        bitn <= '0;
                    end
                end else begin
                    sub <= sub + 4'd1;
                    if (bitn == 4'd0 && sub == 4'(OSR/2 - 1)) begin
                        if (s2) busy <= 1'b0;
                        else begin
                            sub  <= '0;
                            bitn <= 4'd1;
                        end
                    end else if (bitn != 4'd0 && sub == 4'(OSR - 1)) begin
                        sub <= '0;
                        if (bitn <= 4'd8) begin
                            data <= {s2, data[BYTE_W-1:1]};
                            bitn <= bitn + 4'd1;
                        end else begin
                            busy  <= 1'b0;
                            last  <= s2;
                            valid <= s2;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/duo_uart.sv
// Dual serial port top. Decodes the {channel, offset} register bus and
// replicates one channel (rate register, tick generator, transmit queue,
// transmitter, receiver, receive queue, loss flags) NCH times.
// Assumes NCH >= 2 and one access per strobe; read data is registered.
module duo_uart
    import duo_uart_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int FAST_DIV = 1,
    parameter int Q_DEPTH  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(NCH)+1:0]     bus_addr,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [BUS_W-1:0]           bus_wdata,
    output logic [BUS_W-1:0]           bus_rdata,
    input  logic [NCH-1:0]             ser_rx,
    output logic [NCH-1:0]             ser_tx,
    output logic [NCH-1:0]             rx_empty,
    output logic [NCH-1:0]             tx_ovf,
    output logic [NCH-1:0]             rx_ovf
);
    localparam int CH_W   = $clog2(NCH);
    localparam int ADDR_W = CH_W + 2;

    logic [NCH-1:0][BUS_W-1:0] rd_val;
    logic [1:0]                off;
    logic                      unused_hi;

    assign off       = bus_addr[1:0];
    assign unused_hi = ^bus_wdata[BUS_W-1:12];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic              sel, wr_data, rd_data, wr_rate, clr;
        logic [RATE_W-1:0] code;
        logic              tick, tq_empty, tq_full, tq_pop, rq_full, rq_empty;
        logic              rx_valid, txo, tov, rov;
        logic [BYTE_W-1:0] tq_dout, rq_dout, rx_byte;

        assign sel     = (bus_addr[ADDR_W-1:2] == CH_W'(c));
        assign wr_data = bus_wr && sel && (off == OFF_DATA);
        assign rd_data = bus_rd && sel && (off == OFF_DATA);
        assign wr_rate = bus_wr && sel && (off == OFF_RATE);
        assign clr     = bus_wr && sel && (off == OFF_CLEAR);

        // Rate code register, returned to the slowest code by any clear.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) code <= '0;
            else if (wr_rate)  code <= bus_wdata[11:8];
        end

        // Sticky loss flags for both directions.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                tov <= 1'b0;
                rov <= 1'b0;
            end else begin
                if (wr_data && tq_full)  tov <= 1'b1;
                if (rx_valid && rq_full) rov <= 1'b1;
            end
        end

        duo_uart_baud #(.FAST_DIV(FAST_DIV)) u_baud (
            .clk(clk), .rst_n(rst_n), .clr(clr), .code(code), .tick(tick)
        );

        duo_uart_fifo #(.W(BYTE_W), .DEPTH(Q_DEPTH)) u_txq (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .push(wr_data), .din(bus_wdata[BYTE_W-1:0]),
            .pop(tq_pop), .dout(tq_dout), .empty(tq_empty), .full(tq_full)
        );

        duo_uart_tx u_tx (
            .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
            .q_empty(tq_empty), .q_data(tq_dout), .q_pop(tq_pop), .txd(txo)
        );

        duo_uart_rx u_rx (
            .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
            .rxd(ser_rx[c]), .valid(rx_valid), .data(rx_byte)
        );

        duo_uart_fifo #(.W(BYTE_W), .DEPTH(Q_DEPTH)) u_rxq (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .push(rx_valid), .din(rx_byte),
            .pop(rd_data), .dout(rq_dout), .empty(rq_empty), .full(rq_full)
        );

        assign ser_tx[c]   = txo;
        assign rx_empty[c] = rq_empty;
        assign tx_ovf[c]   = tov;
        assign rx_ovf[c]   = rov;
        assign rd_val[c]   = (off == OFF_DATA) ? (rq_empty ? '0 : {8'h00, rq_dout}) :
                             (off == OFF_RATE) ? {4'h0, code, 8'h00} : '0;
    end

    // Registered read return, selected by the channel field.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val[bus_addr[ADDR_W-1:2]];
    end
endmodule

// File: rtl/duo_uart_chk.sv
// Cycle-level properties of the dual serial port, seen only through its ports.
// Bound into every instance of duo_uart.
module duo_uart_chk #(
    parameter int NCH = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [$clog2(NCH)+1:0] bus_addr,
    input logic                   bus_wr,
    input logic                   bus_rd,
    input logic [15:0]            bus_rdata,
    input logic [NCH-1:0]         ser_tx,
    input logic [NCH-1:0]         rx_empty,
    input logic [NCH-1:0]         tx_ovf,
    input logic [NCH-1:0]         rx_ovf
);
    localparam int CH_W = $clog2(NCH);

    // R6: a rate read returns zeros outside the code field.
    assert_rate_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[1:0] == 2'd1) |=> (bus_rdata[15:12] == 4'h0 && bus_rdata[7:0] == 8'h00));

    for (genvar c = 0; c < NCH; c++) begin : g_p
        logic clr_hit, rd_hit;
        assign clr_hit = bus_wr && bus_addr == {CH_W'(c), 2'd2};
        assign rd_hit  = bus_rd && bus_addr == {CH_W'(c), 2'd0};

        // R3: the transmit loss flag holds until a clear.
        assert_tx_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_ovf[c] && !clr_hit) |=> tx_ovf[c]);

        // R8: the receive loss flag holds until a clear.
        assert_rx_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_ovf[c] && !clr_hit) |=> rx_ovf[c]);

        // R7: a clear leaves line idle, queue empty and flags low.
        assert_clear_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
            clr_hit |=> (ser_tx[c] && rx_empty[c] && !tx_ovf[c] && !rx_ovf[c]));

        // R4: a data read of an empty receive queue returns zero.
        assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_hit && rx_empty[c]) |=> (bus_rdata == 16'h0000));
    end
endmodule

bind duo_uart duo_uart_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .ser_tx(ser_tx),
    .rx_empty(rx_empty), .tx_ovf(tx_ovf), .rx_ovf(rx_ovf)
);

// File: tb/duo_uart_tb_top.sv
// Self-checking bench: channels looped A->B and B->A, with an external driver
// that can take over A's input. Queues model the expected receive contents.
module duo_uart_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 2;
    localparam int FAST_DIV   = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  ser_rx, ser_tx, rx_empty, tx_ovf, rx_ovf;
    logic        ext_en = 1'b0, ext_line = 1'b1;

    int n_chk = 0, n_err = 0;
    int rxq [2][$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign ser_rx[0] = ext_en ? ext_line : ser_tx[1];
    assign ser_rx[1] = ser_tx[0];

    duo_uart #(.NCH(NCH), .FAST_DIV(FAST_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_rx(ser_rx), .ser_tx(ser_tx), .rx_empty(rx_empty),
        .tx_ovf(tx_ovf), .rx_ovf(rx_ovf)
    );

    function automatic int bit_cycles(int code);
        return 16 * FAST_DIV * (1 << (8 - code));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int off, input logic [15:0] d);
        @(negedge clk);
        bus_addr = {ch[0], off[1:0]}; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int ch, input int off, output logic [15:0] v);
        @(negedge clk);
        bus_addr = {ch[0], off[1:0]}; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    // Model: a frame arriving at channel dst is queued or lost.
    task automatic note_sent(input int dst, input int b);
        if (rxq[dst].size() < 4) rxq[dst].push_back(b);
    endtask

    task automatic rd_data_chk(input int ch, input string req);
        logic [15:0] v;
        int e;
        e = (rxq[ch].size() > 0) ? rxq[ch].pop_front() : 0;
        rd(ch, 0, v);
        chk(v == 16'(e), req, "data read", v, e);
    endtask

    task automatic wait_low(input int ch);
        for (int i = 0; i < 20000 && ser_tx[ch] !== 1'b0; i++) @(negedge clk);
    endtask

    task automatic measure_low(input int ch, output int n);
        n = 0;
        wait_low(ch);
        while (ser_tx[ch] === 1'b0 && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic capture(input int ch, input int bc, output logic [7:0] d,
                           output logic stopb);
        wait_low(ch);
        repeat (bc/2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (bc) @(negedge clk);
            d[i] = ser_tx[ch];
        end
        repeat (bc) @(negedge clk);
        stopb = ser_tx[ch];
    endtask

    task automatic drive_frame(input logic [7:0] d, input logic stopb, input int bc);
        @(negedge clk);
        ext_line = 1'b0;
        repeat (bc) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            ext_line = d[i];
            repeat (bc) @(negedge clk);
        end
        ext_line = stopb;
        repeat (bc) @(negedge clk);
        ext_line = 1'b1;
        repeat (3*bc) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  d;
        logic        sb;
        int          n;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(ser_tx == 2'b11, "R1", "serial idle", ser_tx, 3);
        chk(rx_empty == 2'b11, "R1", "rx empty", rx_empty, 3);
        chk(tx_ovf == 2'b00 && rx_ovf == 2'b00, "R1", "flags", {tx_ovf, rx_ovf}, 0);
        rd(0, 1, v);
        chk(v == 16'h0000, "R1", "rate A default", v, 0);

        // R4: empty read returns zero, stays empty
        rd_data_chk(0, "R4");
        chk(rx_empty[0] == 1'b1, "R4", "still empty", rx_empty[0], 1);

        // R5: default slowest code gives the longest bit
        fork
            measure_low(0, n);
            wr(0, 0, 16'h0055);
        join
        chk(n == bit_cycles(0), "R5", "code0 start bit", n, bit_cycles(0));

        // R7: clear aborts a frame, data value ignored
        wr(0, 2, 16'hFFFF);
        chk(ser_tx[0] == 1'b1, "R7", "abort line high", ser_tx[0], 1);
        wr(1, 2, 16'h1234);
        chk(rx_empty[1] == 1'b1, "R7", "B flushed", rx_empty[1], 1);
        rd_data_chk(1, "R7");

        // R5/R6: don't-care high bits; read-back format
        wr(0, 1, 16'hF8A5);
        wr(1, 1, 16'h0800);
        rd(0, 1, v);
        chk(v == 16'h0800, "R6", "rate A read", v, 16'h0800);

        // R2: frame shape and loopback delivery
        fork
            capture(0, bit_cycles(8), d, sb);
            wr(0, 0, 16'h00A5);
        join
        note_sent(1, 8'hA5);
        chk(d == 8'hA5, "R2", "decoded bits", d, 8'hA5);
        chk(sb == 1'b1, "R2", "stop bit", sb, 1);
        repeat (300) @(negedge clk);
        rd_data_chk(1, "R2");

        // R5: middle code on B
        wr(0, 1, 16'h0500);
        wr(1, 1, 16'h0500);
        fork
            measure_low(1, n);
            wr(1, 0, 16'h0001);
        join
        chk(n == bit_cycles(5), "R5", "code5 start bit", n, bit_cycles(5));
        note_sent(0, 8'h01);
        repeat (1500) @(negedge clk);
        rd_data_chk(0, "R2");

        // R5: fastest code
        wr(0, 1, 16'h0800);
        wr(1, 1, 16'h0800);
        fork
            measure_low(0, n);
            wr(0, 0, 16'h00FF);
        join
        chk(n == bit_cycles(8), "R5", "code8 start bit", n, bit_cycles(8));
        note_sent(1, 8'hFF);
        repeat (300) @(negedge clk);
        rd_data_chk(1, "R2");

        // R3 and R10: tx overflow on A, B untouched
        wr(1, 1, 16'h0300);
        wr(0, 2, 16'h0000);
        for (int i = 0; i < 4; i++) wr(0, 0, 16'(8'h10 + i));
        chk(tx_ovf[0] == 1'b0, "R3", "no loss at 4", tx_ovf[0], 0);
        wr(0, 0, 16'h0020);
        wr(0, 0, 16'h0021);
        chk(tx_ovf[0] == 1'b1, "R3", "loss flag", tx_ovf[0], 1);
        chk(tx_ovf[1] == 1'b0, "R10", "B tx flag", tx_ovf[1], 0);
        wr(0, 2, 16'h5A5A);
        chk(tx_ovf[0] == 1'b0, "R7", "flag cleared", tx_ovf[0], 0);
        rd(0, 1, v);
        chk(v == 16'h0000, "R7", "rate back to 0", v, 0);
        rd(1, 1, v);
        chk(v == 16'h0300, "R10", "B rate kept", v, 16'h0300);
        wr(1, 2, 16'h0000);

        // R8: rx overflow on B, order kept
        wr(0, 1, 16'h0800);
        wr(1, 1, 16'h0800);
        for (int i = 0; i < 4; i++) begin
            wr(0, 0, 16'(8'h30 + i));
            note_sent(1, 8'h30 + i);
        end
        repeat (1000) @(negedge clk);
        wr(0, 0, 16'h0040); note_sent(1, 8'h40);
        wr(0, 0, 16'h0041); note_sent(1, 8'h41);
        repeat (600) @(negedge clk);
        chk(rx_ovf[1] == 1'b1, "R8", "rx loss flag", rx_ovf[1], 1);
        chk(rx_ovf[0] == 1'b0 && tx_ovf[0] == 1'b0, "R10", "A flags", {rx_ovf[0], tx_ovf[0]}, 0);
        for (int i = 0; i < 5; i++) rd_data_chk(1, "R8");
        chk(rx_empty[1] == 1'b1, "R8", "drained", rx_empty[1], 1);
        wr(1, 2, 16'h0000);
        chk(rx_ovf[1] == 1'b0, "R7", "rx flag cleared", rx_ovf[1], 0);

        // R9: low stop bit discards the frame
        ext_en = 1'b1;
        repeat (20) @(negedge clk);
        drive_frame(8'h5A, 1'b0, bit_cycles(8));
        drive_frame(8'hC3, 1'b1, bit_cycles(8));
        note_sent(0, 8'hC3);
        rd_data_chk(0, "R9");
        rd_data_chk(0, "R9");
        chk(rx_empty[0] == 1'b1, "R9", "nothing left", rx_empty[0], 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule